// File: doc/BRIEF.md
# Memory Access Fault Status Capture

This block records why and where a memory access was refused. A permission checker elsewhere presents a one-cycle result for each CPU or DMA access: a code for the outcome, the direction, the requester, the 22-bit address and two control flags (the saved interrupt-enable flag and the error-report enable). When the outcome is anything other than "allowed", the block loads a 16-bit general status word. Each fault class has its own fixed pattern, with the read and saved-interrupt-enable bits ORed in. In the same cycle it loads two bus status words that hold the refused address, split across the two words under a fixed marker.

Refused DMA accesses can also request a level-7 interrupt, which stays pending until an acknowledge arrives. The requester receives a combinational access-ok answer in the cycle of the check. The status words remain readable at the outputs until the next fault overwrites them.

Top module: `mem_fault_capture`

## Requirements
- R1: After synchronous reset, the general status word, both bus status words, the interrupt request and the fault strobe are all zero.
- R2: On a fault, the general status word starts from a class pattern before any flag bits are added. A page miss (code 1) gives 0xABFF and an access above the user limit (code 2) gives 0xBAFF, for either requester. A privilege violation (code 3) or a write to a read-only page (code 4) gives 0xBBFF for DMA (requester 1) and 0x9BFF for CPU (requester 0).
- R3: Bit 14 (0x4000) of the general status word is set on a fault exactly when the refused access was a read (`acc_read`=1).
- R4: Bit 10 (0x0400) of the general status word is set on a fault exactly when `sie_flag` was 1, for every fault class and requester.
- R5: On any fault, bus status 0 becomes 0x3C00 ORed with address bits 21..16 in its bits 5..0, and bus status 1 becomes address bits 15..0.
- R6: The interrupt request is raised on a DMA fault only when `err_en` is 1. A CPU fault, or a DMA fault with `err_en` at 0, leaves it unchanged.
- R7: A raised interrupt request stays high until a cycle with `irq_ack`=1 clears it. If a new raising fault coincides with the acknowledge, the request stays high.
- R8: A check with code 0 (allowed), or a cycle without `chk_valid`, leaves all three status words unchanged. `acc_ok` is 1 exactly when `chk_valid` is 1 and the code is 0.
- R9: `fault_stb` is high for exactly the one cycle after each cycle that carries a faulting check. The status words show the new values in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | A permission check result is present this cycle |
| chk_code | input | 3 | Result code: 0 allowed, 1 page miss, 2 above user limit, 3 privilege, 4 read-only page |
| acc_read | input | 1 | 1 when the access is a read |
| req_dma | input | 1 | 1 for a DMA requester, 0 for CPU |
| acc_addr | input | 22 | Address of the access |
| sie_flag | input | 1 | Saved interrupt-enable flag |
| err_en | input | 1 | Error reporting enable |
| irq_ack | input | 1 | Clears the pending interrupt request |
| acc_ok | output | 1 | Access permitted (combinational) |
| fault_stb | output | 1 | One-cycle strobe after a fault is captured |
| gen_status | output | 16 | General status word |
| bus_stat0 | output | 16 | Marker plus high address bits |
| bus_stat1 | output | 16 | Low address bits |
| irq7_req | output | 1 | Level-7 interrupt request |

## Verification
The assertions assume that `chk_code` never carries the unused values 5 to 7 while `chk_valid` is high. They also assume that every input is stable around the sampling edge. The sweep respects both assumptions: it drives only codes 0 to 4, and it changes inputs only on the falling clock edge. It walks every combination of code, direction, requester and the two flags, each with a different address. It also covers an acknowledge that arrives in the same cycle as a new interrupt-raising fault.

// File: rtl/fault_pkg.sv
package fault_pkg;

    localparam int STAT_W = 16;

    typedef enum logic [2:0] {
        CHK_ALLOWED     = 3'd0,
        CHK_PAGE_MISS   = 3'd1,
        CHK_ABOVE_LIMIT = 3'd2,
        CHK_PRIV        = 3'd3,
        CHK_READ_ONLY   = 3'd4
    } chk_code_e;

    localparam logic [STAT_W-1:0] PAT_PAGE_MISS  = 16'hABFF;
    localparam logic [STAT_W-1:0] PAT_ABOVE_LIM  = 16'hBAFF;
    localparam logic [STAT_W-1:0] PAT_PROT_DMA   = 16'hBBFF;
    localparam logic [STAT_W-1:0] PAT_PROT_CPU   = 16'h9BFF;
    localparam logic [STAT_W-1:0] BIT_READ       = 16'h4000;
    localparam logic [STAT_W-1:0] BIT_SIE        = 16'h0400;
    localparam logic [STAT_W-1:0] BUS_MARKER     = 16'h3C00;

    typedef struct packed {
        logic              is_fault;
        logic              raise_irq;
        logic [STAT_W-1:0] gstat;
        logic [STAT_W-1:0] bstat0;
        logic [STAT_W-1:0] bstat1;
    } fault_rec_t;

    function automatic logic [STAT_W-1:0] class_pattern(chk_code_e code, logic dma);
        case (code)
            CHK_PAGE_MISS:   return PAT_PAGE_MISS;
            CHK_ABOVE_LIMIT: return PAT_ABOVE_LIM;
            CHK_PRIV,
            CHK_READ_ONLY:   return dma ? PAT_PROT_DMA : PAT_PROT_CPU;
            default:         return '0;
        endcase
    endfunction

    function automatic logic code_is_fault(chk_code_e code);
        return (code == CHK_PAGE_MISS) || (code == CHK_ABOVE_LIMIT) ||
               (code == CHK_PRIV) || (code == CHK_READ_ONLY);
    endfunction

endpackage

// File: rtl/fault_classify.sv
module fault_classify
    import fault_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              valid,
    input  chk_code_e         code,
    input  logic              rd,
    input  logic              dma,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sie,
    input  logic              err_en,
    output logic              ok,
    output fault_rec_t        rec
);
    localparam int HI_W  = ADDR_W - 16;
    localparam int PAD_W = STAT_W - HI_W;

    logic faulty;

    always_comb begin
        faulty        = valid && code_is_fault(code);
        ok            = valid && (code == CHK_ALLOWED);
        rec.is_fault  = faulty;
        rec.raise_irq = faulty && dma && err_en;
        rec.gstat     = class_pattern(code, dma)
                      | (rd  ? BIT_READ : '0)
                      | (sie ? BIT_SIE  : '0);
        rec.bstat0    = BUS_MARKER | {{PAD_W{1'b0}}, addr[ADDR_W-1:16]};
        rec.bstat1    = addr[15:0];
    end

endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
    import fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fault_rec_t        rec,
    output logic              stb,
    output logic [STAT_W-1:0] gstat,
    output logic [STAT_W-1:0] bstat0,
    output logic [STAT_W-1:0] bstat1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stb    <= 1'b0;
            gstat  <= '0;
            bstat0 <= '0;
            bstat1 <= '0;
        end else begin
            stb <= rec.is_fault;
            if (rec.is_fault) begin
                gstat  <= rec.gstat;
                bstat0 <= rec.bstat0;
                bstat1 <= rec.bstat1;
            end
        end
    end

endmodule

// File: rtl/fault_irq_latch.sv
module fault_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic ack,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)          req <= 1'b0;
        else if (set_req) req <= 1'b1;
        else if (ack)     req <= 1'b0;
    end

endmodule

// File: rtl/mem_fault_capture.sv
module mem_fault_capture
    import fault_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic [2:0]        chk_code,
    input  logic              acc_read,
    input  logic              req_dma,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              sie_flag,
    input  logic              err_en,
    input  logic              irq_ack,
    output logic              acc_ok,
    output logic              fault_stb,
    output logic [15:0]       gen_status,
    output logic [15:0]       bus_stat0,
    output logic [15:0]       bus_stat1,
    output logic              irq7_req
);
    fault_rec_t rec;

    fault_classify #(.ADDR_W(ADDR_W)) u_classify (
        .valid  (chk_valid),
        .code   (chk_code_e'(chk_code)),
        .rd     (acc_read),
        .dma    (req_dma),
        .addr   (acc_addr),
        .sie    (sie_flag),
        .err_en (err_en),
        .ok     (acc_ok),
        .rec    (rec)
    );

    fault_status_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .rec    (rec),
        .stb    (fault_stb),
        .gstat  (gen_status),
        .bstat0 (bus_stat0),
        .bstat1 (bus_stat1)
    );

    fault_irq_latch u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_req (rec.raise_irq),
        .ack     (irq_ack),
        .req     (irq7_req)
    );

endmodule

// File: rtl/mem_fault_capture_chk.sv
module mem_fault_capture_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              chk_valid,
    input logic [2:0]        chk_code,
    input logic              acc_read,
    input logic              req_dma,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              sie_flag,
    input logic              err_en,
    input logic              irq_ack,
    input logic              acc_ok,
    input logic              fault_stb,
    input logic [15:0]       gen_status,
    input logic [15:0]       bus_stat0,
    input logic [15:0]       bus_stat1,
    input logic              irq7_req
);
    logic bad_in;
    logic dma_raise;
    assign bad_in    = chk_valid && (chk_code >= 3'd1) && (chk_code <= 3'd4);
    assign dma_raise = bad_in && req_dma && err_en;

    assert_hold_on_allowed_R8: assert property (@(posedge clk) disable iff (rst)
        !bad_in |=> $stable(gen_status) && $stable(bus_stat0) && $stable(bus_stat1));

    assert_strobe_follows_R9: assert property (@(posedge clk) disable iff (rst)
        bad_in |=> fault_stb);

    assert_no_spurious_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !bad_in |=> !fault_stb);

    assert_low_addr_R5: assert property (@(posedge clk) disable iff (rst)
        bad_in |=> bus_stat1 == $past(acc_addr[15:0]));

    assert_marker_R5: assert property (@(posedge clk) disable iff (rst)
        fault_stb |-> bus_stat0[15:6] == 10'h0F0);

    assert_sie_bit_R4: assert property (@(posedge clk) disable iff (rst)
        bad_in |=> gen_status[10] == $past(sie_flag));

    assert_read_bit_R3: assert property (@(posedge clk) disable iff (rst)
        bad_in |=> gen_status[14] == $past(acc_read));

    assert_low_byte_R2: assert property (@(posedge clk) disable iff (rst)
        fault_stb |-> gen_status[7:0] == 8'hFF);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
        irq7_req && !irq_ack |=> irq7_req);

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        !irq7_req && !dma_raise |=> !irq7_req);

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
        dma_raise |=> irq7_req);

    always_comb begin
        if (!rst) begin
            assert_ok_answer_R8: assert (acc_ok == (chk_valid && chk_code == 3'd0));
        end
    end

endmodule

bind mem_fault_capture mem_fault_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chk_valid  (chk_valid),
    .chk_code   (chk_code),
    .acc_read   (acc_read),
    .req_dma    (req_dma),
    .acc_addr   (acc_addr),
    .sie_flag   (sie_flag),
    .err_en     (err_en),
    .irq_ack    (irq_ack),
    .acc_ok     (acc_ok),
    .fault_stb  (fault_stb),
    .gen_status (gen_status),
    .bus_stat0  (bus_stat0),
    .bus_stat1  (bus_stat1),
    .irq7_req   (irq7_req)
);

// File: tb/test_mem_fault_capture.sv
module test_mem_fault_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_valid = 1'b0;
    logic [2:0]  chk_code = 3'd0;
    logic        acc_read = 1'b0;
    logic        req_dma = 1'b0;
    logic [21:0] acc_addr = '0;
    logic        sie_flag = 1'b0;
    logic        err_en = 1'b0;
    logic        irq_ack = 1'b0;
    logic        acc_ok;
    logic        fault_stb;
    logic [15:0] gen_status;
    logic [15:0] bus_stat0;
    logic [15:0] bus_stat1;
    logic        irq7_req;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_g = '0, exp_b0 = '0, exp_b1 = '0;
    logic        exp_irq = 1'b0;

    always #4 clk = ~clk;

    mem_fault_capture i_mem_fault_capture (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_status(int code, bit rd, bit dma, bit sie);
        logic [15:0] b;
        case (code)
            1: b = 16'hABFF;
            2: b = 16'hBAFF;
            default: b = dma ? 16'hBBFF : 16'h9BFF;
        endcase
        return b | (rd ? 16'h4000 : 16'h0) | (sie ? 16'h0400 : 16'h0);
    endfunction

    task automatic apply(int code, bit rd, bit dma, bit sie, bit ee, logic [21:0] a);
        @(negedge clk);
        chk_valid = 1'b1; chk_code = code[2:0]; acc_read = rd; req_dma = dma;
        sie_flag = sie; err_en = ee; acc_addr = a;
        #1;
        check("R8 acc_ok", {31'd0, acc_ok}, {31'd0, code == 0});
        if (code != 0) begin
            exp_g  = model_status(code, rd, dma, sie);
            exp_b0 = 16'h3C00 | {10'd0, a[21:16]};
            exp_b1 = a[15:0];
            if (dma && ee) exp_irq = 1'b1;
        end
        @(negedge clk);
        chk_valid = 1'b0;
        check("R9 strobe", {31'd0, fault_stb}, {31'd0, code != 0});
        check(code == 0 ? "R8 status held" : "R2 R3 R4 status", {16'd0, gen_status}, {16'd0, exp_g});
        check("R5 bus status 0", {16'd0, bus_stat0}, {16'd0, exp_b0});
        check("R5 bus status 1", {16'd0, bus_stat1}, {16'd0, exp_b1});
        check("R6 irq", {31'd0, irq7_req}, {31'd0, exp_irq});
        @(negedge clk);
        check("R9 strobe one cycle", {31'd0, fault_stb}, 32'd0);
        check("R7 irq held", {31'd0, irq7_req}, {31'd0, exp_irq});
        if (exp_irq) begin
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            exp_irq = 1'b0;
            check("R7 irq cleared", {31'd0, irq7_req}, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int idx;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 gstat reset", {16'd0, gen_status}, 32'd0);
        check("R1 bsr0 reset", {16'd0, bus_stat0}, 32'd0);
        check("R1 bsr1 reset", {16'd0, bus_stat1}, 32'd0);
        check("R1 irq reset", {31'd0, irq7_req}, 32'd0);
        check("R1 strobe reset", {31'd0, fault_stb}, 32'd0);
        idx = 0;
        for (int code = 0; code <= 4; code++)
            for (int m = 0; m < 16; m++) begin
                logic [21:0] a;
                a = 22'(idx * 32'h2A5F3 + 32'h1357);
                apply(code, m[0], m[1], m[2], m[3], a);
                idx++;
            end
        // idle cycle with garbage inputs but no valid: nothing changes (R8)
        @(negedge clk);
        chk_code = 3'd1; acc_addr = 22'h3FFFFF;
        @(negedge clk);
        check("R8 no valid", {16'd0, gen_status}, {16'd0, exp_g});
        check("R8 no valid strobe", {31'd0, fault_stb}, 32'd0);
        // acknowledge coinciding with a new raising DMA fault (R7)
        apply(3, 1'b0, 1'b1, 1'b0, 1'b1, 22'h2BCDEF);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R7 cleared before collision", {31'd0, irq7_req}, 32'd0);
        @(negedge clk);
        chk_valid = 1'b1; chk_code = 3'd1; req_dma = 1'b1; err_en = 1'b1;
        acc_read = 1'b1; sie_flag = 1'b1; acc_addr = 22'h012345;
        @(negedge clk);
        chk_valid = 1'b0;
        irq_ack = 1'b1;
        @(negedge clk);
        chk_valid = 1'b1; chk_code = 3'd2;
        @(negedge clk);
        chk_valid = 1'b0; irq_ack = 1'b0;
        check("R7 set wins over ack", {31'd0, irq7_req}, 32'd1);
        check("R2 above-limit dma read", {16'd0, gen_status}, 32'h0000FEFF);
        check("R5 high bits", {16'd0, bus_stat0}, 32'h00003C01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule